// File: doc/BRIEF.md
# Packet-Bus Output Grant Controller

This block sits on the transmit side of an I/O bridge that shares an arbitrated packet bus. The bus moves two packet sizes, a short packet with one data cycle after the header and a long packet with four. The block has one transmit buffer for each size. When the datapath loads a buffer, it sends a one-cycle arm pulse. The controller then raises a coded request toward the arbiter and marks that buffer busy.

When the arbiter grants the bus, the controller steps through the data cycles of the granted size. During those cycles it drives three strobes: a header select, a long-buffer select and a long-buffer advance. A buffer is released only when a grant of its own size has finished, and only if that grant began while the buffer was already marked busy. An arm pulse that lands in the middle of a packet is recorded but is not consumed by that packet.

Top module: `pktbus_out_ctl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `sel_hdr_o`=1, both busy flags are 0, `req_o`=0, `adv_long_o`=0 and `hdr_hit_o`=0.
- R2: In the idle state, `sel_hdr_o`=1 and `sel_long_o` equals `grant_long_i` in the same cycle.
- R3: A grant sampled at a clock edge while idle with `grant_long_i`=0 gives exactly one data cycle. In that cycle `sel_hdr_o`=0 and `sel_long_o`=0, whatever the value of `grant_long_i`. The controller is idle in the cycle after.
- R4: A grant sampled while idle with `grant_long_i`=1 gives exactly four data cycles. In each of them `sel_hdr_o`=0 and `sel_long_o`=1, whatever the value of `grant_long_i`. The controller is idle afterwards.
- R5: `req_o` is combinational. It is 3 in any cycle where `arm_short_i`=1. It is 2 where only `arm_long_i`=1. It is 0 otherwise, except in the case covered by R6.
- R6: When both arm inputs pulse in the same cycle, `req_o` is 3 in that cycle and 2 in the next cycle. Both busy flags are set.
- R7: A busy flag reads 1 from the cycle after its arm pulse. It stays 1 until the clearing event of R9. A grant of the other size never clears it.
- R8: `hdr_hit_o`=1 exactly when the controller is idle and the busy flag of the size selected by `grant_long_i` is 1. Toggling `grant_long_i` changes `hdr_hit_o` but leaves both busy flags unchanged.
- R9: A busy flag clears in the first idle cycle after a same-size grant. That grant must have been sampled while the flag already read 1.
- R10: An arm pulse in the same cycle a grant is sampled, or during any data cycle of that grant, does not let that grant clear the flag. The flag is still 1 after the grant ends.
- R11: `adv_long_o`=1 in the first three data cycles of a long grant that started while `long_busy_o`=1. It is 0 in the fourth data cycle and at all other times.
- R12: An arm pulse in the last data cycle of a grant that would clear its flag keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| grant_i | input | 1 | Bus grant from the arbiter |
| grant_long_i | input | 1 | Grant size: 0 short (1 data cycle), 1 long (4 data cycles) |
| arm_short_i | input | 1 | One-cycle pulse: short buffer loaded |
| arm_long_i | input | 1 | One-cycle pulse: long buffer loaded |
| req_o | output | 2 | Request code: 0 none, 2 long, 3 short |
| hdr_hit_o | output | 1 | Idle and the selected size's buffer is busy |
| sel_hdr_o | output | 1 | Header select, 1 when idle |
| sel_long_o | output | 1 | Long-buffer select |
| short_busy_o | output | 1 | Short buffer holds a packet |
| long_busy_o | output | 1 | Long buffer holds a packet |
| adv_long_o | output | 1 | Advance strobe for the long buffer |

## Verification
A wrong ownership bit shows up as a busy flag that clears one packet early or stays set one packet too long. This is visible on the busy port in the first idle cycle after the grant. For long packets, it also shows on the advance strobe from the first data cycle onward. A wrong beat count shifts the return of `sel_hdr_o` to 1 by at least one cycle, so the bench samples every data cycle. A lost pending long request shows as `req_o` reading 0 instead of 2 in the cycle that follows a double arm.

// File: rtl/obc_pkg.sv
package obc_pkg;
  typedef logic [1:0] req_code_t;
  localparam req_code_t REQ_NONE  = 2'd0;
  localparam req_code_t REQ_LONG  = 2'd2;
  localparam req_code_t REQ_SHORT = 2'd3;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/obc_req_gen.sv
module obc_req_gen
  import obc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_short_i,
  input  logic      arm_long_i,
  output req_code_t req_o
);
  logic pend_q, pend_d;

  // A long request that collides with a short one is deferred one cycle
  always_comb begin
    pend_d = arm_short_i & (arm_long_i | pend_q);
    if (arm_short_i)                req_o = REQ_SHORT;
    else if (arm_long_i || pend_q)  req_o = REQ_LONG;
    else                            req_o = REQ_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_DEFERRED_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_short_i && arm_long_i) |=> (req_o != REQ_NONE)); // R6
endmodule

// File: rtl/obc_grant_seq.sv
module obc_grant_seq
  import obc_pkg::*;
#(
  parameter int SHORT_BEATS = 1,
  parameter int LONG_BEATS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  input  logic grant_long_i,
  output logic idle_o,
  output logic start_o,
  output logic last_o,
  output logic long_o
);
  localparam int MAXB = (LONG_BEATS > SHORT_BEATS) ? LONG_BEATS : SHORT_BEATS;
  localparam int CW   = $clog2(MAXB + 1);

  phase_t        phase_q, phase_d;
  logic          long_q, long_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seq_en;

  always_comb begin
    idle_o  = (phase_q == PH_IDLE);
    start_o = idle_o & grant_i;
    last_o  = (phase_q == PH_DATA) && (cnt_q == CW'(1));
    long_o  = long_q;
    phase_d = phase_q;
    long_d  = long_q;
    cnt_d   = cnt_q;
    seq_en  = start_o | (phase_q == PH_DATA);
    if (start_o) begin
      phase_d = PH_DATA;
      long_d  = grant_long_i;
      cnt_d   = grant_long_i ? CW'(LONG_BEATS) : CW'(SHORT_BEATS);
    end else if (last_o) begin
      phase_d = PH_IDLE;
    end else if (phase_q == PH_DATA) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      long_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      long_q  <= long_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_GRANT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !idle_o); // R3
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !last_o) |=> $stable(long_q)); // R4
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> idle_o); // R4
endmodule

// File: rtl/obc_arm_track.sv
module obc_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o,
  output logic own_o
);
  logic busy_q, busy_d;
  logic own_q, own_d;
  logic trk_en;

  always_comb begin
    trk_en = arm_i | start_i | end_i;
    // a new arm wins over a release in the same cycle
    busy_d = arm_i | (busy_q & ~(end_i & own_q));
    if (start_i)    own_d = busy_q;
    else if (end_i) own_d = 1'b0;
    else            own_d = own_q;
    busy_o = busy_q;
    own_o  = own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= 1'b0;
    end else if (trk_en) begin
      busy_q <= busy_d;
      own_q  <= own_d;
    end
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> busy_o); // R7
  AST_UNOWNED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !own_o) |=> busy_o); // R10
  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !end_i) |=> busy_o); // R7
endmodule

// File: rtl/pktbus_out_ctl.sv
module pktbus_out_ctl
  import obc_pkg::*;
#(
  parameter int SHORT_BEATS = 1,
  parameter int LONG_BEATS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant_i,
  input  logic       grant_long_i,
  input  logic       arm_short_i,
  input  logic       arm_long_i,
  output logic [1:0] req_o,
  output logic       hdr_hit_o,
  output logic       sel_hdr_o,
  output logic       sel_long_o,
  output logic       short_busy_o,
  output logic       long_busy_o,
  output logic       adv_long_o
);
  logic idle, start, last, cur_long;
  logic own_short, own_long;
  req_code_t req;

  obc_req_gen u_req (
    .clk(clk), .rst_n(rst_n),
    .arm_short_i(arm_short_i), .arm_long_i(arm_long_i),
    .req_o(req)
  );

  obc_grant_seq #(.SHORT_BEATS(SHORT_BEATS), .LONG_BEATS(LONG_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .grant_i(grant_i), .grant_long_i(grant_long_i),
    .idle_o(idle), .start_o(start), .last_o(last), .long_o(cur_long)
  );

  obc_arm_track u_short (
    .clk(clk), .rst_n(rst_n),
    .arm_i(arm_short_i),
    .start_i(start & ~grant_long_i),
    .end_i(last & ~cur_long),
    .busy_o(short_busy_o), .own_o(own_short)
  );

  obc_arm_track u_long (
    .clk(clk), .rst_n(rst_n),
    .arm_i(arm_long_i),
    .start_i(start & grant_long_i),
    .end_i(last & cur_long),
    .busy_o(long_busy_o), .own_o(own_long)
  );

  always_comb begin
    req_o      = req;
    sel_hdr_o  = idle;
    sel_long_o = idle ? grant_long_i : cur_long;
    hdr_hit_o  = idle & (grant_long_i ? long_busy_o : short_busy_o);
    adv_long_o = ~idle & cur_long & ~last & own_long;
  end

  AST_ADV_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    adv_long_o |-> long_busy_o); // R11
  AST_ADV_NOT_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hdr_o |-> !adv_long_o); // R11
  AST_HIT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_hit_o |-> sel_hdr_o); // R8
  AST_SHORT_OWN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    own_short |-> short_busy_o); // R9
endmodule

// File: tb/pktbus_out_ctl_tb_top.sv
module pktbus_out_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic grant, glong, arm_s, arm_l;
  logic [1:0] req;
  logic hdr_hit, sel_hdr, sel_long, s_busy, l_busy, adv;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktbus_out_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .grant_i(grant), .grant_long_i(glong),
    .arm_short_i(arm_s), .arm_long_i(arm_l),
    .req_o(req), .hdr_hit_o(hdr_hit), .sel_hdr_o(sel_hdr),
    .sel_long_o(sel_long), .short_busy_o(s_busy),
    .long_busy_o(l_busy), .adv_long_o(adv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // apply inputs for a new cycle and let combinational outputs settle
  task automatic drv(input logic g, input logic gl, input logic as, input logic al);
    @(negedge clk);
    grant = g; glong = gl; arm_s = as; arm_l = al;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = 0; glong = 0; arm_s = 0; arm_l = 0;
    repeat (5) @(negedge clk);
    #1;
    chk("R1 sel_hdr in reset", sel_hdr, 1);
    chk("R1 busy in reset", {s_busy, l_busy}, 0);
    rst_n = 1'b1;
    drv(0, 0, 0, 0);
    chk("R1 sel_hdr", sel_hdr, 1);
    chk("R1 busy", {s_busy, l_busy}, 0);
    chk("R1 req", req, 0);
    chk("R1 adv/hit", {adv, hdr_hit}, 0);
  endtask

  task automatic t_idle_sel();
    drv(0, 1, 0, 0); chk("R2 sel_long follows 1", sel_long, 1);
    drv(0, 0, 0, 0); chk("R2 sel_long follows 0", sel_long, 0);
  endtask

  task automatic t_short_grant();
    drv(1, 0, 0, 0);
    drv(0, 1, 0, 0);
    chk("R3 D1 sel_hdr", sel_hdr, 0);
    chk("R3 D1 sel_long ignores length", sel_long, 0);
    drv(0, 1, 0, 0);
    chk("R3 back idle", sel_hdr, 1);
    chk("R2 idle sel_long", sel_long, 1);
  endtask

  task automatic t_long_grant();
    drv(1, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      drv(0, i[0], 0, 0);
      chk("R4 data sel_hdr", sel_hdr, 0);
      chk("R4 data sel_long", sel_long, 1);
      chk("R11 unowned adv", adv, 0);
    end
    drv(0, 0, 0, 0);
    chk("R4 back idle", sel_hdr, 1);
  endtask

  task automatic t_arm_short();
    drv(0, 0, 1, 0); chk("R5 short req", req, 3);
    drv(0, 0, 0, 0);
    chk("R5 req cleared", req, 0);
    chk("R7 short busy set", s_busy, 1);
    chk("R8 hit on short", hdr_hit, 1);
    drv(0, 1, 0, 0);
    chk("R8 hit off on long", hdr_hit, 0);
    chk("R8 busy unchanged", s_busy, 1);
    drv(1, 1, 0, 0);
    repeat (4) drv(0, 0, 0, 0);
    drv(0, 0, 0, 0);
    chk("R7 long grant keeps short busy", s_busy, 1);
  endtask

  task automatic t_short_clear();
    drv(1, 0, 0, 0);
    drv(0, 0, 0, 0); chk("R9 still busy in D1", s_busy, 1);
    drv(0, 0, 0, 0); chk("R9 cleared at idle", s_busy, 0);
  endtask

  task automatic t_short_midarm();
    drv(1, 0, 1, 0); chk("R5 req with grant", req, 3);
    drv(0, 0, 0, 0);
    drv(0, 0, 0, 0); chk("R10 arm at grant not cleared", s_busy, 1);
    t_short_clear();
    drv(1, 0, 0, 0);
    drv(0, 0, 1, 0);
    drv(0, 0, 0, 0); chk("R10 arm in D1 not cleared", s_busy, 1);
    t_short_clear();
  endtask

  task automatic t_double_arm_long();
    drv(0, 0, 1, 1); chk("R6 first req", req, 3);
    drv(0, 1, 0, 0);
    chk("R6 second req", req, 2);
    chk("R6 both busy", {s_busy, l_busy}, 3);
    drv(1, 1, 0, 0);
    chk("R5 req idle", req, 0);
    chk("R8 hit on long", hdr_hit, 1);
    for (int i = 0; i < 4; i++) begin
      drv(0, 0, 0, 0);
      chk("R11 owned adv", adv, (i < 3) ? 1 : 0);
      chk("R9 long busy during data", l_busy, 1);
    end
    drv(0, 0, 0, 0);
    chk("R9 long cleared", l_busy, 0);
    chk("R7 short kept", s_busy, 1);
    t_short_clear();
  endtask

  task automatic t_long_lastarm();
    drv(0, 0, 0, 1); chk("R5 long req", req, 2);
    drv(1, 1, 0, 0);
    repeat (3) drv(0, 0, 0, 0);
    drv(0, 0, 0, 1);
    chk("R11 D4 adv low", adv, 0);
    chk("R5 req in D4", req, 2);
    drv(0, 0, 0, 0); chk("R12 arm in last keeps flag", l_busy, 1);
    drv(1, 1, 0, 0);
    repeat (4) drv(0, 0, 0, 0);
    drv(0, 0, 0, 0); chk("R9 long cleared again", l_busy, 0);
  endtask

  task automatic t_long_midarm();
    drv(1, 1, 0, 0);
    drv(0, 0, 0, 0);
    drv(0, 0, 0, 1);
    drv(0, 0, 0, 0); chk("R11 no adv after mid arm", adv, 0);
    drv(0, 0, 0, 0);
    drv(0, 0, 0, 0); chk("R10 long mid arm kept", l_busy, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_sel();
    t_short_grant();
    t_long_grant();
    t_arm_short();
    t_short_clear();
    t_short_midarm();
    t_double_arm_long();
    t_long_lastarm();
    t_long_midarm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule